// File: doc/BRIEF.md
# Byte SPI Master Shift Engine

This block is the master end of a byte-wide SPI link. A host write of one byte starts a transfer straight away; the block never waits for a peer, because it owns the serial clock. Over the transfer it produces sixteen serial-clock transitions, sends the byte out with the most significant bit first and collects eight bits from the data-in line. At the end it places the collected byte in a read buffer and raises a sticky completion flag.

Three options set the waveform. The idle level of the serial clock is selectable. An edge-select option decides whether the first data bit is already on the output before the first clock edge, or appears at that edge. A sample-phase option decides whether data-in is taken halfway through each bit or at its end. The bit rate comes from one of four sources: the system clock divided by 4, 16 or 64, or an external one-cycle tick where two ticks make one bit. For receive-only use, the output-enable for data-out can be dropped. The block then keeps clocking and collecting data exactly as in a normal transfer.

Top module: `spi_master_byte`

## Requirements
- R1: With the engine idle, `wr_en_i` high at a rising edge starts a transfer. `busy_o` is high from the next cycle. It produces exactly 16 transitions on `sclk_o` before `busy_o` falls.
- R2: Transmit order is most significant bit first. `mosi_o` presents bit 7 of the written byte first and bit 0 last, so a loop from `mosi_o` to `miso_i` returns the written byte.
- R3: While idle, `sclk_o` sits at the level of `cpol_i` (0 = idle low, 1 = idle high), starting from reset.
- R4: With `cke_i`=1, `mosi_o` shows bit 7 from the cycle after the write, while `sclk_o` is still idle, and later bits change on every second clock transition. With `cke_i`=0, bit 7 first appears at the first clock transition, and later bits change on every second transition from there.
- R5: With `smp_i`=0, `miso_i` is captured at the clock transition halfway through each bit. With `smp_i`=1, it is captured at the transition that ends the bit.
- R6: `rate_sel_i` selects the half-period of the serial clock: 0 gives 2 system cycles, 1 gives 8, 2 gives 32, 3 gives one `ext_tick_i` pulse. A transfer spans 16 half-periods when `cke_i`=1 and 17 when `cke_i`=0. The done flag rises in the cycle after the last one.
- R7: In the cycle after the last half-period, `busy_o` falls, `rd_data_o` holds the received byte, and both `done_o` and `buf_full_o` are set.
- R8: With `dout_en_i`=0, `mosi_oe_o` is low. Reception, flags and timing are unchanged.
- R9: `buf_full_o` clears on `rd_en_i` unless a new byte lands in the same cycle. The read leaves `rd_data_o` unchanged.
- R10: `wr_en_i` during a transfer sets `wcol_o`. The write is otherwise ignored: the current byte and its length are unchanged.
- R11: `done_o` and `wcol_o` stay set until `clr_flags_i` is pulsed. A flag that is set again in the same cycle wins over the clear.
- R12: Synchronous reset `rst_i` aborts any transfer, returns `sclk_o` to the `cpol_i` level and clears all flags and the read buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe for the transmit byte |
| wr_data_i | input | DATA_W | Byte to transmit |
| rd_en_i | input | 1 | Host read of the receive buffer |
| clr_flags_i | input | 1 | Clears the done and collision flags |
| cpol_i | input | 1 | Serial clock idle level |
| cke_i | input | 1 | 1: data valid before the first edge |
| smp_i | input | 1 | 1: sample at bit end, 0: at bit middle |
| rate_sel_i | input | 2 | Bit-rate source select |
| ext_tick_i | input | 1 | External one-cycle rate tick |
| dout_en_i | input | 1 | Data-out enable |
| miso_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for data out |
| busy_o | output | 1 | Transfer in progress |
| rd_data_o | output | DATA_W | Receive buffer |
| done_o | output | 1 | Sticky completion flag |
| buf_full_o | output | 1 | Receive buffer holds an unread byte |
| wcol_o | output | 1 | Write collision flag |

## Verification
The assertions watch, on every cycle, the properties that hold without reference to data. The clock rests at its idle level whenever the engine is idle. It never moves during a transfer except on a rate tick. A divided rate never produces two ticks in a row. A finishing byte sets both flags and drops busy, a write during a transfer marks a collision, and the flags hold until cleared. Other properties depend on the exact transfer, and only the bench scenarios can show them. These are the bit order, the cycle where each data-in bit is sampled under each sample phase, the transfer length at each rate and edge mode, and the collected byte itself. The bench compares them against its reference model on every clock, with random data-in, loopback and collision cases.

// File: rtl/spi_pkg.sv
package spi_pkg;
    typedef enum logic [1:0] {
        RATE_DIV_A = 2'd0,
        RATE_DIV_B = 2'd1,
        RATE_DIV_C = 2'd2,
        RATE_EXT   = 2'd3
    } rate_e;

    typedef struct packed {
        logic  cke;
        logic  smp;
        rate_e rate;
    } xfer_cfg_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int unsigned DIV_A = 4,
    parameter int unsigned DIV_B = 16,
    parameter int unsigned DIV_C = 64
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    input  spi_pkg::rate_e rate_i,
    input  logic          tick_i,
    output logic          half_tick_o
);
    localparam int unsigned CNT_W = $clog2(DIV_C / 2) + 1;
    localparam logic [CNT_W-1:0] LIM_A = CNT_W'(DIV_A / 2 - 1);
    localparam logic [CNT_W-1:0] LIM_B = CNT_W'(DIV_B / 2 - 1);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(DIV_C / 2 - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rg_state_t;

    rg_state_t        st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        st_d        = st_q;
        half_tick_o = 1'b0;
        case (rate_i)
            spi_pkg::RATE_DIV_A: lim = LIM_A;
            spi_pkg::RATE_DIV_B: lim = LIM_B;
            default:             lim = LIM_C;
        endcase
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (rate_i == spi_pkg::RATE_EXT) begin
            half_tick_o = tick_i;
        end else if (st_q.cnt == lim) begin
            half_tick_o = 1'b1;
            st_d.cnt    = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst_i) st_d = '0;
    end

    always_ff @(posedge clk_i) st_q <= st_d;

    // A divided rate never gives ticks on consecutive cycles
    p_div_spacing_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (half_tick_o && rate_i != spi_pkg::RATE_EXT) |=> !half_tick_o);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               start_i,
    input  logic [DATA_W-1:0]  tx_i,
    input  logic               cpol_i,
    input  spi_pkg::xfer_cfg_t cfg_i,
    input  logic               half_tick_i,
    input  logic               miso_i,
    output logic               busy_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output spi_pkg::rate_e     rate_o,
    output logic [DATA_W-1:0]  rx_word_o,
    output logic               byte_done_o
);
    localparam int unsigned NHALF = 2 * DATA_W;
    localparam int unsigned H_W   = $clog2(NHALF + 2);
    localparam logic [H_W-1:0] LAST = H_W'(NHALF);

    typedef struct packed {
        logic               busy;
        logic [H_W-1:0]     h;
        logic               sclk;
        logic               mosi;
        logic [DATA_W-1:0]  tx;
        logic [DATA_W-1:0]  rx;
        spi_pkg::xfer_cfg_t cfg;
    } sh_state_t;

    sh_state_t      st_d, st_q;
    logic [H_W-1:0] step;
    logic           take;

    always_comb begin
        st_d        = st_q;
        byte_done_o = 1'b0;
        step        = '0;
        take        = 1'b0;
        if (!st_q.busy) begin
            st_d.sclk = cpol_i;
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.h    = '0;
                st_d.cfg  = cfg_i;
                st_d.tx   = tx_i;
                st_d.rx   = '0;
                if (cfg_i.cke) st_d.mosi = tx_i[DATA_W-1];
            end
        end else if (half_tick_i) begin
            // position inside the bit grid: odd = mid-bit, even = bit end
            step   = st_q.cfg.cke ? st_q.h + 1'b1 : st_q.h;
            st_d.h = st_q.h + 1'b1;
            if (st_q.cfg.cke || step < LAST) st_d.sclk = ~st_q.sclk;
            if (!st_q.cfg.cke && step == '0) st_d.mosi = st_q.tx[DATA_W-1];
            if (step != '0) begin
                if (step[0]) begin
                    take = !st_q.cfg.smp;
                end else begin
                    take = st_q.cfg.smp;
                    if (step == LAST) begin
                        st_d.busy   = 1'b0;
                        byte_done_o = 1'b1;
                    end else begin
                        st_d.tx   = st_q.tx << 1;
                        st_d.mosi = st_q.tx[DATA_W-2];
                    end
                end
            end
            if (take) st_d.rx = {st_q.rx[DATA_W-2:0], miso_i};
        end
        if (rst_i) begin
            st_d        = '0;
            st_d.sclk   = cpol_i;
            byte_done_o = 1'b0;
        end
    end

    always_ff @(posedge clk_i) st_q <= st_d;

    assign busy_o    = st_q.busy;
    assign sclk_o    = st_q.sclk;
    assign mosi_o    = st_q.mosi;
    assign rate_o    = st_q.cfg.rate;
    assign rx_word_o = st_d.rx;

    p_idle_level_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |=> (sclk_o == $past(cpol_i)));
    p_clock_on_tick_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !half_tick_i) |=> $stable(sclk_o));
    p_end_drops_busy_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_done_o |=> !busy_o);
endmodule

// File: rtl/spi_master_byte.sv
module spi_master_byte #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_A  = 4,
    parameter int unsigned DIV_B  = 16,
    parameter int unsigned DIV_C  = 64
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic              clr_flags_i,
    input  logic              cpol_i,
    input  logic              cke_i,
    input  logic              smp_i,
    input  logic [1:0]        rate_sel_i,
    input  logic              ext_tick_i,
    input  logic              dout_en_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o,
    output logic              buf_full_o,
    output logic              wcol_o
);
    typedef struct packed {
        logic              done;
        logic              full;
        logic              wcol;
        logic [DATA_W-1:0] rbuf;
    } top_state_t;

    top_state_t          st_d, st_q;
    spi_pkg::xfer_cfg_t  cfg;
    spi_pkg::rate_e      act_rate;
    logic                half_tick;
    logic                byte_done;
    logic [DATA_W-1:0]   rx_word;

    assign cfg.cke  = cke_i;
    assign cfg.smp  = smp_i;
    assign cfg.rate = spi_pkg::rate_e'(rate_sel_i);

    spi_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) rate_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .run_i       (busy_o),
        .rate_i      (act_rate),
        .tick_i      (ext_tick_i),
        .half_tick_o (half_tick)
    );

    spi_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .start_i     (wr_en_i),
        .tx_i        (wr_data_i),
        .cpol_i      (cpol_i),
        .cfg_i       (cfg),
        .half_tick_i (half_tick),
        .miso_i      (miso_i),
        .busy_o      (busy_o),
        .sclk_o      (sclk_o),
        .mosi_o      (mosi_o),
        .rate_o      (act_rate),
        .rx_word_o   (rx_word),
        .byte_done_o (byte_done)
    );

    always_comb begin
        st_d = st_q;
        if (byte_done) begin
            st_d.rbuf = rx_word;
            st_d.done = 1'b1;
            st_d.full = 1'b1;
        end else begin
            if (clr_flags_i) st_d.done = 1'b0;
            if (rd_en_i)     st_d.full = 1'b0;
        end
        if (wr_en_i && busy_o) st_d.wcol = 1'b1;
        else if (clr_flags_i)  st_d.wcol = 1'b0;
        if (rst_i) st_d = '0;
    end

    always_ff @(posedge clk_i) st_q <= st_d;

    assign rd_data_o  = st_q.rbuf;
    assign done_o     = st_q.done;
    assign buf_full_o = st_q.full;
    assign wcol_o     = st_q.wcol;
    assign mosi_oe_o  = dout_en_i;

    p_collision_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && busy_o) |=> wcol_o);
    p_finish_flags_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_done |=> (done_o && buf_full_o && !busy_o));
    p_done_sticky_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !clr_flags_i) |=> done_o);
    p_wcol_sticky_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (wcol_o && !clr_flags_i) |=> wcol_o);
endmodule

// File: tb/spi_master_byte_tb.sv
module spi_master_byte_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr = 1'b0, rd = 1'b0, clr = 1'b0;
    logic [7:0] wdata = '0;
    logic       cpol = 1'b0, cke = 1'b0, smp = 1'b0, dout = 1'b1;
    logic [1:0] rate = '0;
    logic       tick = 1'b0, miso = 1'b0;
    logic       sclk, mosi, mosi_oe, busy, done, full, wcol;
    logic [7:0] rdata;

    int checks = 0, failures = 0;
    logic loop_on = 1'b0, ext_on = 1'b0, started = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int tcnt = 0;

    always #2.5 clk = ~clk;

    spi_master_byte dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr), .wr_data_i(wdata), .rd_en_i(rd),
        .clr_flags_i(clr), .cpol_i(cpol), .cke_i(cke), .smp_i(smp),
        .rate_sel_i(rate), .ext_tick_i(tick), .dout_en_i(dout), .miso_i(miso),
        .sclk_o(sclk), .mosi_o(mosi), .mosi_oe_o(mosi_oe), .busy_o(busy),
        .rd_data_o(rdata), .done_o(done), .buf_full_o(full), .wcol_o(wcol)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // data-in source and external tick source
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso <= loop_on ? mosi : lfsr[0];
        tcnt <= tcnt + 1;
        tick <= ext_on && (tcnt % 3 == 0);
    end

    // behavioural reference model
    logic       m_busy, m_sclk, m_mosi, m_done, m_full, m_wcol, m_cke, m_smp, fin, ht, smpl;
    logic [7:0] m_tx, m_rx, m_buf;
    logic [1:0] m_rate;
    int         m_h, m_cnt, half, pos;

    initial begin
        m_busy = 0; m_sclk = 0; m_mosi = 0; m_done = 0; m_full = 0; m_wcol = 0;
        m_cke = 0; m_smp = 0; m_tx = 0; m_rx = 0; m_buf = 0; m_rate = 0; m_h = 0; m_cnt = 0;
    end

    always @(posedge clk) begin
        started <= 1'b1;
        half = (m_rate == 2'd0) ? 2 : (m_rate == 2'd1) ? 8 : 32;
        if (rst) begin
            m_busy = 0; m_h = 0; m_cnt = 0; m_sclk = cpol; m_mosi = 0; m_tx = 0;
            m_rx = 0; m_buf = 0; m_done = 0; m_full = 0; m_wcol = 0;
            m_cke = 0; m_smp = 0; m_rate = 0;
        end else begin
            fin = 0; ht = 0;
            if (m_busy) begin
                if (m_rate == 2'd3) ht = tick;
                else begin
                    ht = (m_cnt == half - 1);
                    m_cnt = ht ? 0 : m_cnt + 1;
                end
            end
            if (wr && m_busy) m_wcol = 1; else if (clr) m_wcol = 0;
            if (!m_busy) begin
                m_sclk = cpol; m_cnt = 0;
                if (wr) begin
                    m_busy = 1; m_h = 0; m_cke = cke; m_smp = smp; m_rate = rate;
                    m_tx = wdata; m_rx = 0;
                    if (cke) m_mosi = wdata[7];
                end
            end else if (ht) begin
                pos = m_h + (m_cke ? 1 : 0);
                m_h++;
                if (m_cke || pos < 16) m_sclk = !m_sclk;
                if (!m_cke && pos == 0) m_mosi = m_tx[7];
                if (pos > 0) begin
                    smpl = (pos % 2 == 1) ? !m_smp : m_smp;
                    if (smpl) m_rx = {m_rx[6:0], miso};
                    if (pos % 2 == 0) begin
                        if (pos == 16) begin fin = 1; m_busy = 0; end
                        else begin m_tx = m_tx << 1; m_mosi = m_tx[7]; end
                    end
                end
            end
            if (fin) begin m_buf = m_rx; m_done = 1; m_full = 1; end
            else begin
                if (clr) m_done = 0;
                if (rd) m_full = 0;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk("R3", "sclk vs model", sclk, m_sclk);
            chk("R2", "mosi vs model", mosi, m_mosi);
            chk("R1", "busy vs model", busy, m_busy);
            chk("R5", "rd_data vs model", rdata, m_buf);
            chk("R11", "done vs model", done, m_done);
            chk("R9", "buf_full vs model", full, m_full);
            chk("R10", "wcol vs model", wcol, m_wcol);
            chk("R8", "mosi_oe", mosi_oe, dout);
        end
    end

    task automatic xfer(input logic [7:0] b, input logic p, input logic e, input logic s,
                        input logic [1:0] r, input logic oe, input logic lp,
                        input logic coll, input int exp_cyc);
        int cyc = 0, tog = 0;
        logic prev;
        @(negedge clk);
        cpol = p; cke = e; smp = s; rate = r; dout = oe; loop_on = lp;
        ext_on = (r == 2'd3); wdata = b; wr = 1'b1; clr = 1'b1;
        @(negedge clk);
        wr = 1'b0; clr = 1'b0;
        chk("R1", "busy after write", busy, 1);
        if (e) begin
            chk("R4", "bit7 before first edge", mosi, b[7]);
            chk("R4", "clock still idle", sclk, p);
        end
        prev = sclk;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            wr = 1'b0;
            if (coll && cyc == 5) begin wr = 1'b1; wdata = ~b; end
            if (sclk != prev) tog++;
            prev = sclk;
        end
        wr = 1'b0;
        chk("R1", "clock transitions", tog, 16);
        chk("R7", "busy low at done", busy, 0);
        chk("R7", "buffer full at done", full, 1);
        if (exp_cyc > 0) chk("R6", "cycles to done", cyc, exp_cyc);
        if (lp) chk("R2", "loopback byte", rdata, b);
        if (coll) chk("R10", "collision flag", wcol, 1);
        ext_on = 1'b0; loop_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "busy after reset", busy, 0);
        chk("R12", "done after reset", done, 0);
        chk("R3", "idle level low", sclk, 0);

        xfer(8'hA5, 0, 1, 0, 2'd0, 1, 1, 0, 32);
        xfer(8'h3C, 1, 0, 1, 2'd1, 1, 1, 0, 136);
        xfer(8'hC3, 0, 0, 0, 2'd2, 1, 1, 0, 544);
        xfer(8'h5A, 1, 1, 1, 2'd3, 1, 1, 0, 0);
        xfer(8'h81, 1, 0, 0, 2'd3, 1, 1, 0, 0);
        // random data-in in every edge/sample combination (R5)
        for (int i = 0; i < 8; i++)
            xfer(8'(i * 37 + 11), i[0], i[1], i[2], 2'd0, 1, 0, 0, i[1] ? 32 : 34);
        // receive only (R8)
        xfer(8'hFF, 0, 1, 1, 2'd1, 0, 0, 0, 128);
        chk("R8", "oe low in receive-only", mosi_oe, 0);
        // collision keeps the original byte and length (R10)
        xfer(8'h96, 0, 1, 0, 2'd0, 1, 1, 1, 32);
        // sticky flags (R11)
        repeat (20) @(negedge clk);
        chk("R11", "done held", done, 1);
        chk("R11", "wcol held", wcol, 1);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk("R11", "done cleared", done, 0);
        chk("R11", "wcol cleared", wcol, 0);
        // read clears full, data kept (R9)
        chk("R9", "full before read", full, 1);
        rd = 1'b1; @(negedge clk); rd = 1'b0;
        chk("R9", "full after read", full, 0);
        chk("R9", "data kept after read", rdata, 8'h96);
        // reset during a transfer (R12)
        cpol = 1'b1; rate = 2'd1; wdata = 8'h77; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        repeat (12) @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R12", "aborted busy", busy, 0);
        chk("R12", "clock idle after reset", sclk, 1);
        chk("R12", "buffer cleared", rdata, 0);
        chk("R12", "full cleared", full, 0);
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R1 watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule